// File: doc/BRIEF.md
# Serial Magnitude Comparator, Most Significant Bit First

This block compares two unsigned binary operands that arrive one bit pair per clock. The leading bits come first. A small decision machine keeps the relation of the bits seen so far. It starts out as "equal" and moves to "less" or "greater" at the first position where the two bits differ. Once it has decided, it keeps that decision, because no lower-order bit can overturn a difference at a higher position.

To run one comparison, a client pulses the restart strobe and then presents the operand bits, from the top bit downward, on the cycles where the enable is high. After the last enabled pair has been clocked in, the three one-hot outputs give the relation of the whole words. The operand length is not fixed. The client decides how many pairs to send, and the block itself counts nothing.

Top module: `serial_mag_cmp`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the next state is "equal": after that edge `eq` is 1 and `lt` and `gt` are 0.
- R2: Exactly one of `lt`, `eq` and `gt` is 1 on every cycle.
- R3: In the equal state, an enabled cycle with `xBit`=0 and `yBit`=1 (and no restart) gives `lt`=1 after the edge.
- R4: In the equal state, an enabled cycle with `xBit`=1 and `yBit`=0 (and no restart) gives `gt`=1 after the edge.
- R5: In the equal state, an enabled cycle with `xBit` equal to `yBit` leaves `eq`=1.
- R6: Once `lt` or `gt` is 1, it stays 1 whatever bits are presented, until a restart or a reset.
- R7: On a cycle with `en`=0 and no restart, the outputs do not change, whatever bits are presented.
- R8: A restart strobe forces the equal state at the next edge. It takes priority over `en` and over the bit inputs.
- R9: After a restart followed by N enabled bit pairs sent leading bit first, the outputs match the integer comparison of the two N-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Clears the decision back to equal; takes priority over `en` |
| en | input | 1 | Qualifies the current bit pair |
| xBit | input | 1 | Current bit of operand X |
| yBit | input | 1 | Current bit of operand Y |
| lt | output | 1 | X is less than Y for the bits seen so far |
| eq | output | 1 | X equals Y for the bits seen so far |
| gt | output | 1 | X is greater than Y for the bits seen so far |

## Verification
The hardest case to reach from the ports is a decision made on the very first pair, followed by many lower-order pairs that point the other way. Only this case shows that a decision cannot be overturned. Random operands seldom produce it over long words, so the stimulus includes directed operands where the top bits favour one side and every later bit favours the other. It also includes operands that differ only in the final bit. Restarts are also issued while a decision is held and while `en` is high with unequal bits, so that their priority is tested directly.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_EQ  = 2'b00,
    ST_LT  = 2'b01,
    ST_GT  = 2'b10,
    ST_BAD = 2'b11
  } cmpState_t;

  typedef struct packed {
    logic restart;
    logic advance;
    logic goLt;
    logic goGt;
  } ctrlStrobe_t;
endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
(
  input  logic        restart,
  input  logic        en,
  input  logic        xBit,
  input  logic        yBit,
  input  cmpState_t   curState,
  output ctrlStrobe_t strobe
);
  logic inEqual;
  logic inBad;

  always_comb begin
    inEqual        = (curState == ST_EQ);
    inBad          = (curState == ST_BAD);
    // Restart wins; an illegal code is scrubbed on the next enabled cycle.
    strobe.restart = restart | (en & inBad);
    // Only the undecided state looks at the bits; decided states absorb.
    strobe.advance = en & ~restart & inEqual;
    strobe.goLt    = ~xBit & yBit;
    strobe.goGt    = xBit & ~yBit;
  end
endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobe,
  output cmpState_t   curState,
  output logic        lt,
  output logic        eq,
  output logic        gt
);
  cmpState_t stateQ;

  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      stateQ <= ST_EQ;
    end else if (strobe.advance && strobe.goLt) begin
      stateQ <= ST_LT;
    end else if (strobe.advance && strobe.goGt) begin
      stateQ <= ST_GT;
    end
  end

  always_comb begin
    curState = stateQ;
    lt       = (stateQ == ST_LT);
    gt       = (stateQ == ST_GT);
    // The illegal code reads as equal so the outputs stay one-hot.
    eq       = ~(lt | gt);
  end
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
  import smc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  input  logic xBit,
  input  logic yBit,
  output logic lt,
  output logic eq,
  output logic gt
);
  cmpState_t   curState;
  ctrlStrobe_t strobe;

  smc_ctrl u_ctrl (
    .restart (restart),
    .en      (en),
    .xBit    (xBit),
    .yBit    (yBit),
    .curState(curState),
    .strobe  (strobe)
  );

  smc_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .curState(curState),
    .lt      (lt),
    .eq      (eq),
    .gt      (gt)
  );
endmodule

// File: rtl/serial_mag_cmp_props.sv
module serial_mag_cmp_props (
  input logic clk,
  input logic rst,
  input logic restart,
  input logic en,
  input logic xBit,
  input logic yBit,
  input logic lt,
  input logic eq,
  input logic gt
);
  p_reset_eq_r1: assert property (@(posedge clk) rst |=> eq);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({lt, eq, gt}) == 1);

  p_go_lt_r3: assert property (@(posedge clk) disable iff (rst)
    (eq && en && !restart && !xBit && yBit) |=> lt);

  p_go_gt_r4: assert property (@(posedge clk) disable iff (rst)
    (eq && en && !restart && xBit && !yBit) |=> gt);

  p_eq_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (eq && en && !restart && (xBit == yBit)) |=> eq);

  p_lt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (lt && !restart) |=> lt);

  p_gt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (gt && !restart) |=> gt);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> $stable({lt, eq, gt}));

  p_restart_eq_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> eq);
endmodule

bind serial_mag_cmp serial_mag_cmp_props u_props (
  .clk    (clk),
  .rst    (rst),
  .restart(restart),
  .en     (en),
  .xBit   (xBit),
  .yBit   (yBit),
  .lt     (lt),
  .eq     (eq),
  .gt     (gt)
);

// File: tb/serial_mag_cmp_test.sv
module serial_mag_cmp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic en = 1'b0;
  logic xBit = 1'b0;
  logic yBit = 1'b0;
  logic lt, eq, gt;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic sampleReq = 1'b0;
  logic [2:0] expQ[$];

  always #2 clk = ~clk;

  serial_mag_cmp uut (
    .clk(clk), .rst(rst), .restart(restart), .en(en),
    .xBit(xBit), .yBit(yBit), .lt(lt), .eq(eq), .gt(gt)
  );

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({lt, eq, gt} !== exp) begin
      fails++;
      $display("FAIL %s: {lt,eq,gt} actual=%b expected=%b", req, {lt, eq, gt}, exp);
    end
  endtask

  function automatic logic [2:0] refCmp(input logic [31:0] a, input logic [31:0] b);
    if (a < b) return 3'b100;
    if (a > b) return 3'b001;
    return 3'b010;
  endfunction

  // Driver: restart, stream bits top first, then queue the expected result.
  task automatic runCompare(input int len, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] ma, mb;
    ma = (len == 32) ? a : (a & ((32'd1 << len) - 1));
    mb = (len == 32) ? b : (b & ((32'd1 << len) - 1));
    @(negedge clk); restart = 1'b1; en = 1'b1; xBit = 1'b1; yBit = 1'b0;
    @(negedge clk); restart = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      xBit = ma[i]; yBit = mb[i]; en = 1'b1;
      @(negedge clk);
    end
    en = 1'b0; xBit = ~xBit; yBit = ~yBit;
    expQ.push_back(refCmp(ma, mb));
    sampleReq = 1'b1;
    @(negedge clk); sampleReq = 1'b0;
  endtask

  // Monitor: pop and compare while the enable is low (R9).
  initial begin
    forever begin
      @(posedge clk);
      if (sampleReq && expQ.size() > 0) begin
        logic [2:0] e;
        e = expQ.pop_front();
        #1 check("R9 serial compare", e);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{1, 4, 8, 16, 32};
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b010);
    check("R2 one-hot at reset", 3'b010);
    rst = 1'b0;

    // R7: enable low with unequal bits leaves equal.
    @(negedge clk); en = 1'b0; xBit = 1'b1; yBit = 1'b0;
    @(negedge clk); check("R7 idle ignores bits", 3'b010);
    // R5: equal bits keep equal.
    en = 1'b1; xBit = 1'b1; yBit = 1'b1;
    @(negedge clk); check("R5 equal pair", 3'b010);
    xBit = 1'b0; yBit = 1'b0;
    @(negedge clk); check("R5 equal zero pair", 3'b010);
    // R3: x=0,y=1 decides less.
    xBit = 1'b0; yBit = 1'b1;
    @(negedge clk); check("R3 decide lt", 3'b100);
    // R6: opposite bits do not overturn.
    repeat (5) begin
      xBit = 1'b1; yBit = 1'b0;
      @(negedge clk); check("R6 lt sticky", 3'b100);
    end
    // R8: restart with en high and differing bits.
    restart = 1'b1; xBit = 1'b1; yBit = 1'b0;
    @(negedge clk); restart = 1'b0; check("R8 restart from lt", 3'b010);
    // R4: x=1,y=0 decides greater.
    xBit = 1'b1; yBit = 1'b0;
    @(negedge clk); check("R4 decide gt", 3'b001);
    xBit = 1'b0; yBit = 1'b1;
    @(negedge clk); check("R6 gt sticky", 3'b001);
    en = 1'b0;
    @(negedge clk); check("R7 idle holds gt", 3'b001);
    restart = 1'b1;
    @(negedge clk); restart = 1'b0; check("R8 restart with en low", 3'b010);
    // R1: reset mid-decision.
    en = 1'b1; xBit = 1'b1; yBit = 1'b0;
    @(negedge clk); check("R4 decide gt again", 3'b001);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; en = 1'b0; check("R1 reset clears gt", 3'b010);

    // R9 directed corners.
    runCompare(32, 32'h8000_0000, 32'h7FFF_FFFF);
    runCompare(32, 32'h7FFF_FFFF, 32'h8000_0000);
    runCompare(16, 32'h0000_1234, 32'h0000_1235);
    runCompare(8, 32'hA5, 32'hA5);
    runCompare(1, 32'h1, 32'h0);
    runCompare(1, 32'h0, 32'h0);
    // R9 random words of several lengths.
    foreach (lens[k]) begin
      repeat (20) begin
        logic [31:0] a, b;
        a = $urandom; b = $urandom;
        if ($urandom_range(0, 3) == 0) b = a;
        runCompare(lens[k], a, b);
      end
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule